// File: doc/BRIEF.md
# Interrupt Controller Setup and Command Decoder

This block is the programming front end of an eight-line interrupt controller. A host writes and reads single bytes on a port with one address line. The block turns those writes into the controller's configuration: the line mask, the vector base, and the nesting and automatic end-of-interrupt modes. It also emits one-cycle command strobes that the external priority logic acts on. It steers host reads to the request register, the in-service register, the mask, or a poll answer.

On address 0, data bit 4 starts a setup sequence of three or four bytes, and the first byte chooses which length. Otherwise data bit 3 marks a read-control byte, and the remaining values form a command in bits 7:5. On address 1, a byte either continues the setup sequence or, when no sequence is open, replaces the mask.

The request and in-service registers come from outside the block, together with the priority logic's current winner. The block only reports them and tells the priority logic what to change.

Top module: `irq_cmd_seq`

## Requirements
- R1: After reset the mask, vector base, all mode bits, read select, special mask and poll flag are 0, no setup sequence is open, and no strobe is active.
- R2: A write to address 0 with data bit 4 set loads `need_fourth` from bit 0. It clears the mask, `spec_mask` and `read_isr`, pulses `init_stb` for one cycle (clear rotation origin and last input levels), and opens the sequence at the base step.
- R3: A setup start with bit 0 clear also clears `spec_nest` and `auto_eoi`. With bit 0 set, both keep their values.
- R4: At the base step an address-1 write stores data AND 0xF8 as `vec_base`. The next address-1 write is consumed without effect and closes the sequence, or moves it to the mode step when `need_fourth` is 1.
- R5: At the mode step an address-1 write sets `spec_nest` from bit 4 and `auto_eoi` from bit 1, then closes the sequence.
- R6: An address-1 write with no sequence open loads the mask. The mask changes on no other write.
- R7: An address-0 write with bit 4 clear and bit 3 set arms poll when bit 2 is 1. When bit 1 is 1 it loads `read_isr` from bit 0. When bit 6 is 1 it loads `spec_mask` from bit 5.
- R8: An address-0 write with bits 4 and 3 clear whose bits 7:5 equal 1 (non-specific end), 5 (non-specific end with rotation), 3 (specific end), 6 (set priority) or 7 (specific rotate) pulses `cmd_stb` for the one cycle after the write. During that cycle `cmd_op` carries that code and `cmd_line` carries data bits 2:0.
- R9: Command codes 0 and 4 set `rot_auto_eoi` from bit 7 without a strobe. Code 2 changes nothing.
- R10: A read while poll is armed returns `best_line` zero-extended when `best_valid` is 1, and 7 otherwise. It disarms poll. When a line was returned, `poll_ack` pulses the next cycle with `poll_line` equal to that line.
- R11: With poll not armed, `rd_data` shows `isr_bits` at address 0 when `read_isr` is 1, `req_bits` at address 0 when it is 0, and the mask at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (consumes a poll) |
| addr | input | 1 | Port address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, combinational |
| req_bits | input | 8 | Request register from priority logic |
| isr_bits | input | 8 | In-service register from priority logic |
| best_valid | input | 1 | Priority logic has a line to grant |
| best_line | input | 3 | Line the priority logic would grant |
| mask | output | 8 | Line mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| need_fourth | output | 1 | Setup sequence includes the mode byte |
| spec_nest | output | 1 | Special nesting mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_auto_eoi | output | 1 | Rotate on automatic end of interrupt |
| spec_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | Address-0 read shows in-service register |
| poll_armed | output | 1 | Next read is a poll |
| init_stb | output | 1 | Setup started: clear rotation origin and levels |
| cmd_stb | output | 1 | Command strobe |
| cmd_op | output | 3 | Command code |
| cmd_line | output | 3 | Line field of the command |
| poll_ack | output | 1 | Poll consumed a line: clear its request and service bits |
| poll_line | output | 3 | Line consumed by the poll |

## Verification
The bench aims at the sequence length. A setup started without the mode byte must treat the fourth byte as a mask write; a design that always waits for four bytes would swallow it and keep the old mask. It checks that a setup start with bit 0 clear drops nesting and automatic end, and that one with bit 0 set keeps them. It sends read-control bytes with their enable bits clear, which a careless decoder would let overwrite read select or special mask. It covers the command codes that must not strobe (0, 2, 4) and a poll with no winner, where a wrong design would return the stale line or raise `poll_ack`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_LINK = 2'd2,
        SEQ_MODE = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        WK_NONE  = 3'd0,
        WK_INIT  = 3'd1,
        WK_RDCTL = 3'd2,
        WK_CMD   = 3'd3,
        WK_DATA  = 3'd4
    } wr_kind_e;

    typedef enum logic [2:0] {
        CMD_ROT_CLR = 3'd0,
        CMD_NS_EOI  = 3'd1,
        CMD_NOP     = 3'd2,
        CMD_SP_EOI  = 3'd3,
        CMD_ROT_SET = 3'd4,
        CMD_NS_ROT  = 3'd5,
        CMD_SET_PRI = 3'd6,
        CMD_SP_ROT  = 3'd7
    } cmd_code_e;

    function automatic wr_kind_e classify(input logic we, input logic a,
                                          input logic [7:0] d);
        if (!we)       return WK_NONE;
        else if (a)    return WK_DATA;
        else if (d[4]) return WK_INIT;
        else if (d[3]) return WK_RDCTL;
        else           return WK_CMD;
    endfunction

    function automatic logic cmd_strobes(input cmd_code_e c);
        return (c == CMD_NS_EOI) || (c == CMD_NS_ROT) || (c == CMD_SP_EOI) ||
               (c == CMD_SET_PRI) || (c == CMD_SP_ROT);
    endfunction

endpackage

// File: rtl/irq_setup_seq.sv
module irq_setup_seq
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] vec_base,
    output logic              need_fourth,
    output logic              spec_nest,
    output logic              auto_eoi,
    output logic              init_stb
);
    localparam logic [DATA_W-1:0] LOW_BITS  = DATA_W'((1 << LINE_W) - 1);
    localparam logic [DATA_W-1:0] BASE_KEEP = ~LOW_BITS;

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            mask        <= '0;
            vec_base    <= '0;
            need_fourth <= 1'b0;
            spec_nest   <= 1'b0;
            auto_eoi    <= 1'b0;
            init_stb    <= 1'b0;
        end else begin
            init_stb <= 1'b0;
            case (kind)
                WK_INIT: begin
                    need_fourth <= wr_data[0];
                    mask        <= '0;
                    init_stb    <= 1'b1;
                    state       <= SEQ_BASE;
                    if (!wr_data[0]) begin
                        spec_nest <= 1'b0;
                        auto_eoi  <= 1'b0;
                    end
                end
                WK_DATA: begin
                    case (state)
                        SEQ_IDLE: mask <= wr_data;
                        SEQ_BASE: begin
                            vec_base <= wr_data & BASE_KEEP;
                            state    <= SEQ_LINK;
                        end
                        SEQ_LINK: state <= need_fourth ? SEQ_MODE : SEQ_IDLE;
                        SEQ_MODE: begin
                            spec_nest <= wr_data[4];
                            auto_eoi  <= wr_data[1];
                            state     <= SEQ_IDLE;
                        end
                        default: state <= SEQ_IDLE;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_op_ctl.sv
module irq_op_ctl
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              best_valid,
    input  logic [LINE_W-1:0] best_line,
    output logic              rot_auto_eoi,
    output logic              spec_mask,
    output logic              read_isr,
    output logic              poll_armed,
    output logic              cmd_stb,
    output logic [2:0]        cmd_op,
    output logic [LINE_W-1:0] cmd_line,
    output logic              poll_ack,
    output logic [LINE_W-1:0] poll_line
);
    cmd_code_e code;
    logic      poll_take;
    wire       unused_bits = ^wr_data[4:3];

    assign code      = cmd_code_e'(wr_data[7:5]);
    assign poll_take = rd_en && poll_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            rot_auto_eoi <= 1'b0;
            spec_mask    <= 1'b0;
            read_isr     <= 1'b0;
            poll_armed   <= 1'b0;
            cmd_stb      <= 1'b0;
            cmd_op       <= '0;
            cmd_line     <= '0;
            poll_ack     <= 1'b0;
            poll_line    <= '0;
        end else begin
            cmd_stb  <= 1'b0;
            poll_ack <= 1'b0;
            if (poll_take) begin
                poll_armed <= 1'b0;
                if (best_valid) begin
                    poll_ack  <= 1'b1;
                    poll_line <= best_line;
                end
            end
            case (kind)
                WK_INIT: begin
                    spec_mask <= 1'b0;
                    read_isr  <= 1'b0;
                end
                WK_RDCTL: begin
                    if (wr_data[2]) poll_armed <= 1'b1;
                    if (wr_data[1]) read_isr   <= wr_data[0];
                    if (wr_data[6]) spec_mask  <= wr_data[5];
                end
                WK_CMD: begin
                    if (code == CMD_ROT_CLR || code == CMD_ROT_SET)
                        rot_auto_eoi <= wr_data[7];
                    if (cmd_strobes(code)) begin
                        cmd_stb  <= 1'b1;
                        cmd_op   <= code;
                        cmd_line <= wr_data[LINE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_rd_steer.sv
module irq_rd_steer #(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              addr,
    input  logic              poll_armed,
    input  logic              read_isr,
    input  logic              best_valid,
    input  logic [LINE_W-1:0] best_line,
    input  logic [DATA_W-1:0] req_bits,
    input  logic [DATA_W-1:0] isr_bits,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] NO_LINE = DATA_W'({LINE_W{1'b1}});

    always_comb begin
        if (poll_armed)
            rd_data = best_valid ? DATA_W'(best_line) : NO_LINE;
        else if (addr)
            rd_data = mask;
        else
            rd_data = read_isr ? isr_bits : req_bits;
    end
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] req_bits,
    input  logic [DATA_W-1:0] isr_bits,
    input  logic              best_valid,
    input  logic [LINE_W-1:0] best_line,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] vec_base,
    output logic              need_fourth,
    output logic              spec_nest,
    output logic              auto_eoi,
    output logic              rot_auto_eoi,
    output logic              spec_mask,
    output logic              read_isr,
    output logic              poll_armed,
    output logic              init_stb,
    output logic              cmd_stb,
    output logic [2:0]        cmd_op,
    output logic [LINE_W-1:0] cmd_line,
    output logic              poll_ack,
    output logic [LINE_W-1:0] poll_line
);
    wr_kind_e kind;

    assign kind = classify(wr_en, addr, wr_data[7:0]);

    irq_setup_seq #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_setup (
        .clk(clk), .rst(rst), .kind(kind), .wr_data(wr_data),
        .mask(mask), .vec_base(vec_base), .need_fourth(need_fourth),
        .spec_nest(spec_nest), .auto_eoi(auto_eoi), .init_stb(init_stb)
    );

    irq_op_ctl #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_op (
        .clk(clk), .rst(rst), .kind(kind), .wr_data(wr_data),
        .rd_en(rd_en), .best_valid(best_valid), .best_line(best_line),
        .rot_auto_eoi(rot_auto_eoi), .spec_mask(spec_mask),
        .read_isr(read_isr), .poll_armed(poll_armed), .cmd_stb(cmd_stb),
        .cmd_op(cmd_op), .cmd_line(cmd_line), .poll_ack(poll_ack),
        .poll_line(poll_line)
    );

    irq_rd_steer #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_rd (
        .addr(addr), .poll_armed(poll_armed), .read_isr(read_isr),
        .best_valid(best_valid), .best_line(best_line),
        .req_bits(req_bits), .isr_bits(isr_bits), .mask(mask),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/irq_cmd_seq_chk.sv
module irq_cmd_seq_chk #(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              best_valid,
    input logic [LINE_W-1:0] best_line,
    input logic [DATA_W-1:0] mask,
    input logic [DATA_W-1:0] vec_base,
    input logic              spec_mask,
    input logic              read_isr,
    input logic              poll_armed,
    input logic              init_stb,
    input logic              cmd_stb,
    input logic [2:0]        cmd_op,
    input logic              poll_ack,
    input logic [LINE_W-1:0] poll_line
);
    // R8: a strobe follows a command-class write on address 0
    assert_cmd_src_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> $past(wr_en && !addr && !wr_data[4] && !wr_data[3]));

    // R9: codes 0, 2 and 4 never strobe
    assert_cmd_code_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> (cmd_op != 3'd0 && cmd_op != 3'd2 && cmd_op != 3'd4));

    // R2: setup start leaves mask, special mask and read select cleared
    assert_init_clr_R2: assert property (@(posedge clk) disable iff (rst)
        init_stb |-> (mask == '0 && !spec_mask && !read_isr));

    // R6: mask moves only after a write
    assert_mask_src_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(mask) |-> $past(wr_en));

    // R4: base keeps its low line bits at zero
    assert_base_low_R4: assert property (@(posedge clk) disable iff (rst)
        vec_base[LINE_W-1:0] == '0);

    // R10: acknowledge only after a poll read that found a line
    assert_poll_ack_R10: assert property (@(posedge clk) disable iff (rst)
        poll_ack |-> ($past(rd_en && poll_armed && best_valid) &&
                      poll_line == $past(best_line)));
endmodule

bind irq_cmd_seq irq_cmd_seq_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/test_irq_cmd_seq.sv
module test_irq_cmd_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wr_data = '0, req_bits = '0, isr_bits = '0;
    logic       best_valid = 1'b0;
    logic [2:0] best_line = '0;
    logic [7:0] rd_data, mask, vec_base;
    logic       need_fourth, spec_nest, auto_eoi, rot_auto_eoi, spec_mask;
    logic       read_isr, poll_armed, init_stb, cmd_stb, poll_ack;
    logic [2:0] cmd_op, cmd_line, poll_line;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    int m_mask, m_base, m_need4, m_nest, m_aeoi, m_rot, m_smask, m_risr;
    int m_poll, m_st, m_init, m_cstb, m_cop, m_cline, m_pack, m_pline;

    irq_cmd_seq i_irq_cmd_seq (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = 0; m_base = 0; m_need4 = 0; m_nest = 0; m_aeoi = 0;
        m_rot = 0; m_smask = 0; m_risr = 0; m_poll = 0; m_st = 0;
        m_init = 0; m_cstb = 0; m_cop = 0; m_cline = 0; m_pack = 0;
        m_pline = 0;
    endtask

    task automatic model_step();
        int d, c;
        d = wr_data;
        m_init = 0; m_cstb = 0; m_pack = 0;
        if (rd_en && m_poll != 0) begin
            m_poll = 0;
            if (best_valid) begin m_pack = 1; m_pline = best_line; end
        end
        if (wr_en && addr) begin
            if (m_st == 0) m_mask = d;
            else if (m_st == 1) begin m_base = d & 'hF8; m_st = 2; end
            else if (m_st == 2) m_st = m_need4 ? 3 : 0;
            else begin m_nest = (d >> 4) & 1; m_aeoi = (d >> 1) & 1; m_st = 0; end
        end else if (wr_en && (d & 'h10) != 0) begin
            m_need4 = d & 1; m_mask = 0; m_smask = 0; m_risr = 0;
            m_init = 1; m_st = 1;
            if (m_need4 == 0) begin m_nest = 0; m_aeoi = 0; end
        end else if (wr_en && (d & 'h08) != 0) begin
            if ((d & 'h04) != 0) m_poll = 1;
            if ((d & 'h02) != 0) m_risr = d & 1;
            if ((d & 'h40) != 0) m_smask = (d >> 5) & 1;
        end else if (wr_en) begin
            c = d >> 5;
            if (c == 0 || c == 4) m_rot = c >> 2;
            else if (c != 2) begin m_cstb = 1; m_cop = c; m_cline = d & 7; end
        end
    endtask

    // reference model advanced and compared every clock
    always @(posedge clk) begin
        #1;
        if (rst) model_reset();
        else begin
            model_step();
            chk("R6 mask", mask, m_mask);
            chk("R4 vec_base", vec_base, m_base);
            chk("R2 need_fourth", need_fourth, m_need4);
            chk("R5 spec_nest", spec_nest, m_nest);
            chk("R5 auto_eoi", auto_eoi, m_aeoi);
            chk("R9 rot_auto_eoi", rot_auto_eoi, m_rot);
            chk("R7 spec_mask", spec_mask, m_smask);
            chk("R7 read_isr", read_isr, m_risr);
            chk("R7 poll_armed", poll_armed, m_poll);
            chk("R2 init_stb", init_stb, m_init);
            chk("R8 cmd_stb", cmd_stb, m_cstb);
            if (m_cstb != 0) begin
                chk("R8 cmd_op", cmd_op, m_cop);
                chk("R8 cmd_line", cmd_line, m_cline);
            end
            chk("R10 poll_ack", poll_ack, m_pack);
            if (m_pack != 0) chk("R10 poll_line", poll_line, m_pline);
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input string tag);
        int exp;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        if (m_poll != 0) exp = best_valid ? int'(best_line) : 7;
        else if (a) exp = m_mask;
        else exp = (m_risr != 0) ? int'(isr_bits) : int'(req_bits);
        chk(tag, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    end

    initial begin
        req_bits = 8'h5A; isr_bits = 8'h81;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", mask, 0);
        chk("R1 vec_base", vec_base, 0);
        chk("R1 modes", {need_fourth, spec_nest, auto_eoi, rot_auto_eoi}, 0);
        chk("R1 read ctl", {spec_mask, read_isr, poll_armed}, 0);
        chk("R1 strobes", {init_stb, cmd_stb, poll_ack}, 0);
        rd(1'b1, "R11 mask read after reset");
        wr(1'b1, 8'h96);                  // R6 write with no sequence open
        rd(1'b1, "R11 mask read");

        // four-byte setup
        wr(1'b0, 8'h11);
        chk("R2 mask cleared", mask, 0);
        wr(1'b1, 8'h4D);                  // R4 base -> 0x48
        chk("R4 base", vec_base, 8'h48);
        wr(1'b1, 8'hFF);                  // link byte, no effect
        chk("R4 mask untouched by link", mask, 0);
        wr(1'b1, 8'h12);                  // R5 nest=1 aeoi=1
        chk("R5 nest", spec_nest, 1);
        chk("R5 aeoi", auto_eoi, 1);
        wr(1'b1, 8'hA5);
        chk("R6 mask after setup", mask, 8'hA5);

        // R3 four-byte restart keeps modes, then three-byte drops them
        wr(1'b0, 8'h1F);
        chk("R3 nest kept", spec_nest, 1);
        wr(1'b1, 8'h27);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);                  // mode byte: clears both
        wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h00); wr(1'b1, 8'h12);
        wr(1'b0, 8'h10);
        chk("R3 nest cleared", spec_nest, 0);
        chk("R3 aeoi cleared", auto_eoi, 0);
        wr(1'b1, 8'h27);
        chk("R4 base 0x20", vec_base, 8'h20);
        wr(1'b1, 8'h33);                  // link closes sequence
        wr(1'b1, 8'h3C);                  // R4 must land in mask
        chk("R4 three-byte then mask", mask, 8'h3C);

        // read control R7 / reads R11
        wr(1'b0, 8'h0B);
        rd(1'b0, "R11 isr read");
        wr(1'b0, 8'h09);                  // bit1 clear: no change
        rd(1'b0, "R7 read select kept");
        wr(1'b0, 8'h0A);
        rd(1'b0, "R11 req read");
        wr(1'b0, 8'h68);
        chk("R7 special mask on", spec_mask, 1);
        wr(1'b0, 8'h08);                  // bit6 clear: no change
        chk("R7 special mask kept", spec_mask, 1);
        wr(1'b0, 8'h48);
        chk("R7 special mask off", spec_mask, 0);

        // poll R10
        best_valid = 1'b1; best_line = 3'd5;
        wr(1'b0, 8'h0C);
        rd(1'b0, "R10 poll line");
        rd(1'b0, "R11 after poll");
        best_valid = 1'b0; best_line = 3'd2;
        wr(1'b0, 8'h0C);
        rd(1'b1, "R10 poll none");
        rd(1'b1, "R11 mask after poll");

        // commands R8 / R9
        wr(1'b0, 8'h20);
        wr(1'b0, 8'hA0);
        wr(1'b0, 8'h63);
        wr(1'b0, 8'hC4);
        wr(1'b0, 8'hE6);
        wr(1'b0, 8'h80);
        chk("R9 rotate set", rot_auto_eoi, 1);
        wr(1'b0, 8'h47);                  // code 2: nothing
        chk("R9 nop keeps rotate", rot_auto_eoi, 1);
        chk("R9 nop keeps mask", mask, 8'h3C);
        wr(1'b0, 8'h00);
        chk("R9 rotate clear", rot_auto_eoi, 0);
        wr(1'b1, 8'hC3);
        rd(1'b1, "R11 final mask");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    end
endmodule